// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This block holds a file of thirty-two 128-bit vector registers and answers byte-gather requests against it. A request carries eight 8-bit indices packed into one 64-bit word, a starting register, a table length of one to four registers and a 64-bit initial word. The selected registers are treated as one contiguous byte table. Each index picks one byte of that table, and the picked bytes are assembled into a 64-bit result in the lane order of the indices.

The table is built from consecutive register numbers and wraps from register 31 back to register 0. An index that falls beyond the table does not select anything. Its result byte takes a fill value instead. In zeroing mode the fill is 0x00. In keep mode the fill is the matching byte of the initial word, which lets a caller merge lookups into an existing destination.

Requests enter through a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The result leaves through a second valid/ready handshake, with one output register in between. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that has not been taken stays unchanged and holds off new requests. Registers are loaded through a plain synchronous write port.

Top module: `vtbl_lookup`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0, `res_data` is all zeros and `req_ready` is 1.
- R2: For lane k (k = 0..7), the index is `req_idx[8k+7:8k]` and the lane's result goes to `res_data[8k+7:8k]`. An index i inside the table selects byte (i mod 16) of register (`req_base` + i/16) mod 32. Byte b of a register is bits [8b+7:8b], so bytes 0..7 form the low doubleword and bytes 8..15 form the high doubleword.
- R3: `req_len` encodes the register count as `req_len`+1, so 0 means 1 register and 3 means 4 registers. An index is inside the table exactly when it is below 16 × (`req_len`+1). Any index of 128 or more is always outside.
- R4: When `req_keep` is 0, every lane whose index is outside the table yields 0x00, and `req_init` has no effect on the result.
- R5: When `req_keep` is 1, every lane whose index is outside the table yields the matching byte of `req_init`.
- R6: Register numbers wrap from 31 to 0. For example, with base 31, index 16 reads byte 0 of register 0.
- R7: An accepted request produces `res_valid` = 1 with its result on the next clock edge. When `res_valid` is high and `res_ready` is high, the result is consumed at that edge.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_data` holds its value, `req_ready` is 0, and no request is accepted.
- R9: When `wr_en` is high, `wr_data` is written to register `wr_addr` at the clock edge. A lookup accepted at that same edge still sees the old contents. A lookup accepted at a later edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 128 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_base | input | 5 | First register of the table |
| req_len | input | 2 | Register count minus one |
| req_keep | input | 1 | 1 = keep mode, 0 = zeroing mode |
| req_idx | input | 64 | Eight packed byte indices |
| req_init | input | 64 | Initial result word used as fill in keep mode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream accepts the result |
| res_data | output | 64 | Looked-up result word |

## Verification
The bench aims at the table boundary for each of the four lengths by pairing the last in-range index with the first out-of-range one. A design with an off-by-one limit would return a table byte where fill is expected, or fill where a byte is expected. Wrap is exercised with bases 30 and 31 and multi-register tables. A design that carried the register sum into a sixth bit, or clamped at register 31, would read the wrong register. Both fill modes are run with a non-zero initial word, so zeroing mode leaking `req_init` shows up. The bench also stalls the output while a second request waits, and issues a write in the same cycle as a lookup of that register. A design that dropped or overwrote the held result, or forwarded the new write data, would disagree with the expected words.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int unsigned REG_W    = 128;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned LANES    = 8;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LEN_W    = 2;
  localparam int unsigned REG_AW   = $clog2(NUM_REGS);
  localparam int unsigned WORD_W   = LANES * BYTE_W;
endpackage

// File: rtl/vtbl_regfile.sv
module vtbl_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 128,
  parameter int unsigned NRD  = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [W-1:0]  rdata [NRD]
);
  logic [W-1:0] store [NREG];

  // Contents are not reset; they are undefined until written.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Reads are combinational and return contents before any same-edge write.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = store[raddr[p]];
  end
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane #(
  parameter int unsigned REG_W  = 128,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LEN_W  = 2,
  localparam int unsigned BSEL_W = $clog2(REG_W / 8)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_AW-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              keep,
  input  logic [7:0]        fill_in,
  output logic [REG_AW-1:0] rd_reg,
  input  logic [REG_W-1:0]  rd_val,
  output logic [7:0]        out_byte
);
  logic [IDX_W:0]      limit;
  logic                in_tbl;
  logic [BSEL_W-1:0]   bsel;
  logic [IDX_W-1:0]    reg_off;
  logic [7:0]          picked;

  // Table size in bytes: (len + 1) registers of REG_W/8 bytes each.
  assign limit   = ((IDX_W+1)'(len) + (IDX_W+1)'(1)) << BSEL_W;
  assign in_tbl  = ({1'b0, idx} < limit);
  assign reg_off = idx >> BSEL_W;
  // Truncation to REG_AW bits gives the wrap from the last register to 0.
  assign rd_reg  = base + REG_AW'(reg_off);
  assign bsel    = idx[BSEL_W-1:0];
  assign picked  = rd_val[{bsel, 3'b000} +: 8];

  always_comb begin
    if (in_tbl)     out_byte = picked;
    else if (keep)  out_byte = fill_in;
    else            out_byte = 8'h00;
  end
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup
  import vtbl_pkg::*;
#(
  parameter int unsigned P_REG_W    = REG_W,
  parameter int unsigned P_NUM_REGS = NUM_REGS,
  parameter int unsigned P_LANES    = LANES,
  parameter int unsigned P_LEN_W    = LEN_W,
  localparam int unsigned AW        = $clog2(P_NUM_REGS),
  localparam int unsigned DW        = P_LANES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [P_REG_W-1:0] wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_base,
  input  logic [P_LEN_W-1:0] req_len,
  input  logic               req_keep,
  input  logic [DW-1:0]      req_idx,
  input  logic [DW-1:0]      req_init,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DW-1:0]      res_data
);
  logic [AW-1:0]      lane_reg [P_LANES];
  logic [P_REG_W-1:0] lane_val [P_LANES];
  logic [DW-1:0]      gathered;
  logic               accept;

  vtbl_regfile #(
    .NREG (P_NUM_REGS),
    .W    (P_REG_W),
    .NRD  (P_LANES)
  ) u_rf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (lane_reg),
    .rdata (lane_val)
  );

  for (genvar k = 0; k < P_LANES; k++) begin : g_lane
    vtbl_lane #(
      .REG_W  (P_REG_W),
      .REG_AW (AW),
      .IDX_W  (8),
      .LEN_W  (P_LEN_W)
    ) u_lane (
      .idx      (req_idx[8*k +: 8]),
      .base     (req_base),
      .len      (req_len),
      .keep     (req_keep),
      .fill_in  (req_init[8*k +: 8]),
      .rd_reg   (lane_reg[k]),
      .rd_val   (lane_val[k]),
      .out_byte (gathered[8*k +: 8])
    );
  end

  // A single output register: a new request fits when it is empty or draining.
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= gathered;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vtbl_lookup_chk.sv
module vtbl_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_keep,
  input logic [63:0] req_idx,
  input logic [63:0] req_init,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_data
);
  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // Lane 0 index of 128 or more lies outside every table length.
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_keep && req_idx[7]) |=> (res_data[7:0] == 8'h00));

  assert_keep_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_keep && req_idx[7]) |=> (res_data[7:0] == $past(req_init[7:0])));
endmodule

bind vtbl_lookup vtbl_lookup_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_keep  (req_keep),
  .req_idx   (req_idx),
  .req_init  (req_init),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/sim_vtbl_lookup.sv
`timescale 1ns/1ps
module sim_vtbl_lookup;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [4:0]   req_base = '0;
  logic [1:0]   req_len = '0;
  logic         req_keep = 1'b0;
  logic [63:0]  req_idx = '0;
  logic [63:0]  req_init = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [63:0]  res_data;

  logic [127:0] mdl [32];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vtbl_lookup u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base), .req_len(req_len),
    .req_keep(req_keep), .req_idx(req_idx), .req_init(req_init),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int r, int j);
    return 8'((r * 73) ^ (j * 17) ^ 8'h5A);
  endfunction

  // Expected word from the requirement text (R2..R6).
  function automatic logic [63:0] expect_word(logic [4:0] base, logic [1:0] len,
                                              logic keep, logic [63:0] idx, logic [63:0] init);
    logic [63:0] w;
    w = '0;
    for (int k = 0; k < 8; k++) begin
      int ix;
      ix = int'(idx[8*k +: 8]);
      if (ix < 16 * (int'(len) + 1)) begin
        int r;
        r = (int'(base) + ix / 16) % 32;
        w[8*k +: 8] = mdl[r][8*(ix % 16) +: 8];
      end else begin
        w[8*k +: 8] = keep ? init[8*k +: 8] : 8'h00;
      end
    end
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(int r, logic [127:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[r] = v;
  endtask

  task automatic lookup(string tag, logic [4:0] base, logic [1:0] len, logic keep,
                        logic [63:0] idx, logic [63:0] init);
    logic [63:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_len = len; req_keep = keep;
    req_idx = idx; req_init = init; res_ready = 1'b1;
    e = expect_word(base, len, keep, idx, init);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {63'd0, res_valid}, 64'd1);
    check(tag, res_data, e);
  endtask

  task automatic t_reset;
    check("R1 res_valid", {63'd0, res_valid}, 64'd0);
    check("R1 res_data", res_data, 64'd0);
    check("R1 req_ready", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_basic;
    lookup("R2 base3 len4", 5'd3, 2'd3, 1'b0, {8'd63, 8'd48, 8'd33, 8'd17, 8'd15, 8'd8, 8'd7, 8'd0}, '0);
    lookup("R2 base0 len1", 5'd0, 2'd0, 1'b0, {8'd1, 8'd3, 8'd5, 8'd7, 8'd9, 8'd11, 8'd13, 8'd14}, '0);
    lookup("R2 base20 len2", 5'd20, 2'd1, 1'b1, {8'd31, 8'd16, 8'd0, 8'd24, 8'd9, 8'd2, 8'd30, 8'd12}, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_range;
    lookup("R3 len1 edge", 5'd4, 2'd0, 1'b1, {8'd15, 8'd16, 8'd15, 8'd16, 8'd0, 8'd17, 8'd14, 8'd255}, 64'h1122_3344_5566_7788);
    lookup("R3 len2 edge", 5'd9, 2'd1, 1'b1, {8'd31, 8'd32, 8'd31, 8'd32, 8'd16, 8'd33, 8'd30, 8'd128}, 64'h99AA_BBCC_DDEE_FF00);
    lookup("R3 len3 edge", 5'd12, 2'd2, 1'b1, {8'd47, 8'd48, 8'd47, 8'd48, 8'd32, 8'd49, 8'd46, 8'd200}, 64'hCAFE_F00D_1234_5678);
    lookup("R3 len4 edge", 5'd17, 2'd3, 1'b1, {8'd63, 8'd64, 8'd63, 8'd64, 8'd48, 8'd65, 8'd62, 8'd127}, 64'h0F1E_2D3C_4B5A_6978);
  endtask

  task automatic t_zero;
    lookup("R4 all out", 5'd2, 2'd0, 1'b0, {8{8'd200}}, 64'hFFFF_FFFF_FFFF_FFFF);
    lookup("R4 mixed", 5'd2, 2'd1, 1'b0, {8'd40, 8'd5, 8'd33, 8'd20, 8'd255, 8'd31, 8'd32, 8'd0}, 64'hA5A5_A5A5_A5A5_A5A5);
  endtask

  task automatic t_keep;
    lookup("R5 all out", 5'd6, 2'd2, 1'b1, {8{8'd129}}, 64'h0102_0304_0506_0708);
    lookup("R5 mixed", 5'd6, 2'd0, 1'b1, {8'd16, 8'd3, 8'd100, 8'd15, 8'd64, 8'd0, 8'd255, 8'd8}, 64'hF0E1_D2C3_B4A5_9687);
  endtask

  task automatic t_wrap;
    lookup("R6 base31", 5'd31, 2'd3, 1'b0, {8'd63, 8'd48, 8'd32, 8'd31, 8'd16, 8'd15, 8'd8, 8'd0}, '0);
    lookup("R6 base30", 5'd30, 2'd3, 1'b0, {8'd40, 8'd33, 8'd47, 8'd32, 8'd18, 8'd31, 8'd2, 8'd16}, '0);
  endtask

  task automatic t_flow;
    logic [63:0] ea;
    logic [63:0] eb;
    ea = expect_word(5'd1, 2'd0, 1'b0, 64'h0001_0203_0405_0607, '0);
    eb = expect_word(5'd7, 2'd1, 1'b0, 64'h1F1E_1D1C_1B1A_1918, '0);
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1; req_base = 5'd1; req_len = 2'd0; req_keep = 1'b0;
    req_idx = 64'h0001_0203_0405_0607; req_init = '0;
    @(negedge clk);
    check("R7 valid after accept", {63'd0, res_valid}, 64'd1);
    check("R7 data A", res_data, ea);
    req_base = 5'd7; req_len = 2'd1; req_idx = 64'h1F1E_1D1C_1B1A_1918;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R8 held data", res_data, ea);
      check("R8 ready low", {63'd0, req_ready}, 64'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 valid for B", {63'd0, res_valid}, 64'd1);
    check("R7 data B", res_data, eb);
    @(negedge clk);
    check("R7 drained", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic t_write;
    logic [63:0] e_old;
    logic [127:0] nv;
    nv = {16{8'hC3}} ^ 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100;
    e_old = expect_word(5'd5, 2'd0, 1'b0, 64'h0F0E_0908_0706_0100, '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = nv;
    req_valid = 1'b1; req_base = 5'd5; req_len = 2'd0; req_keep = 1'b0;
    req_idx = 64'h0F0E_0908_0706_0100; req_init = '0; res_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R9 same-edge old", res_data, e_old);
    mdl[5] = nv;
    lookup("R9 new contents", 5'd5, 2'd0, 1'b0, 64'h0F0E_0908_0706_0100, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    for (int r = 0; r < 32; r++) begin
      logic [127:0] v;
      for (int j = 0; j < 16; j++) v[8*j +: 8] = pat(r, j);
      write_reg(r, v);
    end
    t_basic;
    t_range;
    t_zero;
    t_keep;
    t_wrap;
    t_flow;
    t_write;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule